// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a three-wire stereo PCM stream (bit clock, frame clock, serial data) into parallel left and right sample words. All three serial lines are brought into the system clock domain through a synchroniser. Each bit is taken on a rising edge of the bit clock. One 3-bit code selects the framing (right-justified, left-justified or I2S) and the word length (16, 20 or 24 bits). One control bit swaps which frame-clock level stands for the left channel.

A second operating mode takes the left channel on the main data pin and the right channel on a second data pin, both in the same frame. In this mode the word length is 20 or 24 bits and the framing is left- or right-justified, each picked by its own control bit. In both modes every word is sign-extended to the output width. The two words are presented together with a single-cycle valid strobe.

Top module: `audrx_top`

## Requirements
- R1: Serial bits are taken only on rising edges of the bit clock, most significant bit first, in every mode.
- R2: In single-pin mode, format code 000 selects 16-bit right-justified, 001 selects 20-bit right-justified, 010 selects 24-bit right-justified, 011 selects 24-bit left-justified, 100 selects 16-bit I2S, 101 selects 24-bit I2S, 110 selects 20-bit I2S and 111 selects 20-bit left-justified.
- R3: In right-justified framing, the word is the last N bits received before a frame-clock transition. Earlier bits in that slot are ignored.
- R4: In left-justified framing, the word is the first N bits received from the frame-clock transition onward. Later bits in that slot are ignored.
- R5: In I2S framing, the first bit after a frame-clock transition is ignored and the next N bits form the word.
- R6: With the swap bit at 0, frame clock high marks the left slot; with it at 1, frame clock low marks the left slot. The left word of a sample instant precedes the right word.
- R7: After a right word completes, pair_valid pulses high for exactly one cycle, with the most recent left word on left_out and that right word on right_out. A right word with no preceding left word is dropped.
- R8: Outputs carry the N-bit word sign-extended to 24 bits.
- R9: In dual-pin mode with left-justified framing, both words start at the frame-clock falling edge (rising edge when the swap bit is 1). Left data comes from sdata_in and right data from sdata2_in.
- R10: In dual-pin mode with right-justified framing, both words end just before the frame-clock rising edge (falling edge when the swap bit is 1).
- R11: In dual-pin mode, dual_w24 at 1 selects 24-bit words and at 0 selects 20-bit words. sdata2_in is ignored in single-pin mode.
- R12: Synchronous active-high reset clears the outputs to zero, holds pair_valid low, and discards any partially received word, so that only complete slots received after reset produce output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| lrclk_in | input | 1 | Frame clock marking channel slots |
| sdata_in | input | 1 | Main serial data; left data in dual-pin mode |
| sdata2_in | input | 1 | Right-channel serial data in dual-pin mode |
| dual_en | input | 1 | 1 selects dual-pin mode |
| fmt_code | input | 3 | Framing and word-length code for single-pin mode |
| lr_swap | input | 1 | Inverts the meaning of the frame-clock level |
| dual_lj | input | 1 | Dual-pin framing: 1 left-justified, 0 right-justified |
| dual_w24 | input | 1 | Dual-pin word length: 1 for 24 bits, 0 for 20 bits |
| left_out | output | 24 | Left sample, sign-extended |
| right_out | output | 24 | Right sample, sign-extended |
| pair_valid | output | 1 | One-cycle strobe when a left/right pair is presented |

## Verification
The bench builds the block with its default parameters: 24-bit outputs, a two-stage synchroniser and a 6-bit slot counter. This makes every one of the eight single-pin codes and all four dual-pin combinations reachable, each run under both frame-clock polarities. Every run uses 32-bit slots with the unused positions filled with ones. Words at the positive and negative extremes, all ones and mixed patterns therefore test framing offsets and sign extension together. Each run also begins with a partial frame cut short by reset.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

  typedef enum logic [1:0] {
    FRM_RJ  = 2'd0,
    FRM_LJ  = 2'd1,
    FRM_I2S = 2'd2
  } frm_e;

  typedef struct packed {
    frm_e       frm;
    logic [4:0] len;
  } slot_cfg_t;

  // Single-pin mode: {i2s, iw1, iw0}
  function automatic slot_cfg_t decode_code(input logic [2:0] code);
    slot_cfg_t c;
    case (code)
      3'b000:  begin c.frm = FRM_RJ;  c.len = 5'd16; end
      3'b001:  begin c.frm = FRM_RJ;  c.len = 5'd20; end
      3'b010:  begin c.frm = FRM_RJ;  c.len = 5'd24; end
      3'b011:  begin c.frm = FRM_LJ;  c.len = 5'd24; end
      3'b100:  begin c.frm = FRM_I2S; c.len = 5'd16; end
      3'b101:  begin c.frm = FRM_I2S; c.len = 5'd24; end
      3'b110:  begin c.frm = FRM_I2S; c.len = 5'd20; end
      default: begin c.frm = FRM_LJ;  c.len = 5'd20; end
    endcase
    return c;
  endfunction

  function automatic slot_cfg_t decode_dual(input logic lj, input logic w24);
    slot_cfg_t c;
    c.frm = lj ? FRM_LJ : FRM_RJ;
    c.len = w24 ? 5'd24 : 5'd20;
    return c;
  endfunction

endpackage

// File: rtl/audrx_sync.sv
module audrx_sync #(
  parameter int STAGES = 2,
  parameter int NDATA  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_raw,
  input  logic [NDATA-1:0] data_raw,
  output logic [NDATA-1:0] data_s,
  output logic             bclk_rise
);
  localparam int PW = NDATA + 1;

  logic [PW-1:0] pipe [STAGES];
  logic          bclk_last;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) pipe[0] <= '0;
          else     pipe[0] <= {bclk_raw, data_raw};
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) pipe[g] <= '0;
          else     pipe[g] <= pipe[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) bclk_last <= 1'b0;
    else     bclk_last <= pipe[STAGES-1][PW-1];
  end

  assign data_s    = pipe[STAGES-1][NDATA-1:0];
  assign bclk_rise = pipe[STAGES-1][PW-1] & ~bclk_last;

endmodule

// File: rtl/audrx_lane.sv
module audrx_lane #(
  parameter int DEPTH = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [DEPTH-1:0] shreg
);
  always_ff @(posedge clk) begin
    if (rst)           shreg <= '0;
    else if (shift_en) shreg <= {shreg[DEPTH-2:0], bit_in};
  end
endmodule

// File: rtl/audrx_framer.sv
module audrx_framer
  import audrx_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  input  logic             lr,
  input  logic             dual_en,
  input  logic [2:0]       fmt_code,
  input  logic             lr_swap,
  input  logic             dual_lj,
  input  logic             dual_w24,
  output logic             cap_l,
  output logic             cap_r,
  output logic             cap_skip,
  output logic [LEN_W-1:0] cap_len,
  output logic             cap_dual
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  slot_cfg_t        cfg;
  logic             lr_prev, primed;
  logic [CNT_W-1:0] cnt, kcur, cnt_nxt, target, len_c;
  logic             is_left, chg, ref_edge, rj, hit, slot_left;

  always_comb begin
    cfg      = dual_en ? decode_dual(dual_lj, dual_w24) : decode_code(fmt_code);
    is_left  = lr ^ lr_swap;
    chg      = lr ^ lr_prev;
    ref_edge = chg & (~dual_en | (dual_lj ? ~is_left : is_left));
    kcur     = ref_edge ? '0 : cnt;
    cnt_nxt  = (kcur == CNT_MAX) ? kcur : kcur + CNT_W'(1);
    len_c    = CNT_W'(cfg.len);
    target   = len_c - CNT_W'(1) + ((cfg.frm == FRM_I2S) ? CNT_W'(1) : '0);
    rj       = (cfg.frm == FRM_RJ);
    hit      = rj ? (ref_edge & primed & (cnt >= len_c))
                  : ((primed | ref_edge) & (kcur == target));
    slot_left = rj ? ~is_left : is_left;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_prev  <= 1'b0;
      primed   <= 1'b0;
      cnt      <= '0;
      cap_l    <= 1'b0;
      cap_r    <= 1'b0;
      cap_skip <= 1'b0;
      cap_len  <= '0;
      cap_dual <= 1'b0;
    end else begin
      cap_l <= 1'b0;
      cap_r <= 1'b0;
      if (rise) begin
        lr_prev <= lr;
        cnt     <= cnt_nxt;
        if (ref_edge) primed <= 1'b1;
        cap_l    <= hit & (dual_en | slot_left);
        cap_r    <= hit & (dual_en | ~slot_left);
        cap_skip <= rj;
        cap_len  <= LEN_W'(cfg.len);
        cap_dual <= dual_en;
      end
    end
  end

  p_cap_on_rise_r1: assert property (@(posedge clk) disable iff (rst)
    (cap_l || cap_r) |-> $past(rise));

  p_one_chan_r6: assert property (@(posedge clk) disable iff (rst)
    !cap_dual |-> !(cap_l && cap_r));

endmodule

// File: rtl/audrx_pair.sv
module audrx_pair #(
  parameter int OUT_W = 24,
  parameter int LEN_W = 5,
  parameter int DEPTH = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_l,
  input  logic             cap_r,
  input  logic             cap_skip,
  input  logic [LEN_W-1:0] cap_len,
  input  logic             cap_dual,
  input  logic [DEPTH-1:0] lane0,
  input  logic [DEPTH-1:0] lane1,
  output logic [OUT_W-1:0] left_out,
  output logic [OUT_W-1:0] right_out,
  output logic             pair_valid
);
  function automatic logic [OUT_W-1:0] sext(input logic [DEPTH-1:0] sh,
                                            input logic skip,
                                            input logic [LEN_W-1:0] len);
    logic [DEPTH-1:0] v;
    logic [OUT_W-1:0] r;
    v = skip ? (sh >> 1) : sh;
    r = '0;
    if (len != '0) begin
      for (int i = 0; i < OUT_W; i++)
        r[i] = (i < int'(len)) ? v[i] : v[int'(len) - 1];
    end
    return r;
  endfunction

  logic [OUT_W-1:0] w0, w1, hold_l;
  logic             left_ok;
  logic [LEN_W-1:0] out_len;

  always_comb begin
    w0 = sext(lane0, cap_skip, cap_len);
    w1 = sext(lane1, cap_skip, cap_len);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_out   <= '0;
      right_out  <= '0;
      pair_valid <= 1'b0;
      hold_l     <= '0;
      left_ok    <= 1'b0;
      out_len    <= '0;
    end else begin
      pair_valid <= 1'b0;
      if (cap_dual) begin
        if (cap_l && cap_r) begin
          left_out   <= w0;
          right_out  <= w1;
          pair_valid <= 1'b1;
          out_len    <= cap_len;
        end
      end else if (cap_l) begin
        hold_l  <= w0;
        left_ok <= 1'b1;
      end else if (cap_r && left_ok) begin
        left_out   <= hold_l;
        right_out  <= w0;
        pair_valid <= 1'b1;
        left_ok    <= 1'b0;
        out_len    <= cap_len;
      end
    end
  end

  logic [OUT_W-1:0] hi_mask;
  always_comb begin
    for (int i = 0; i < OUT_W; i++) hi_mask[i] = (i >= int'(out_len));
  end

  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  p_sext_r8: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && out_len != '0) |->
      ((right_out & hi_mask) == (right_out[out_len - 1'b1] ? hi_mask : '0)));

  p_reset_r12: assert property (@(posedge clk)
    rst |=> (!pair_valid && left_out == '0 && right_out == '0));

endmodule

// File: rtl/audrx_top.sv
module audrx_top #(
  parameter int OUT_W       = 24,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk_in,
  input  logic             lrclk_in,
  input  logic             sdata_in,
  input  logic             sdata2_in,
  input  logic             dual_en,
  input  logic [2:0]       fmt_code,
  input  logic             lr_swap,
  input  logic             dual_lj,
  input  logic             dual_w24,
  output logic [OUT_W-1:0] left_out,
  output logic [OUT_W-1:0] right_out,
  output logic             pair_valid
);
  localparam int LANES = 2;
  localparam int DEPTH = OUT_W + 1;
  localparam int LEN_W = $clog2(OUT_W + 1);

  logic [LANES:0]   raw_lines, sync_lines;
  logic             rise;
  logic [DEPTH-1:0] lane_sh [LANES];
  logic             cap_l, cap_r, cap_skip, cap_dual;
  logic [LEN_W-1:0] cap_len;

  assign raw_lines = {lrclk_in, sdata2_in, sdata_in};

  audrx_sync #(.STAGES(SYNC_STAGES), .NDATA(LANES + 1)) u_sync (
    .clk(clk), .rst(rst), .bclk_raw(bclk_in), .data_raw(raw_lines),
    .data_s(sync_lines), .bclk_rise(rise)
  );

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      audrx_lane #(.DEPTH(DEPTH)) u_lane (
        .clk(clk), .rst(rst), .shift_en(rise), .bit_in(sync_lines[g]),
        .shreg(lane_sh[g])
      );
    end
  endgenerate

  audrx_framer #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_framer (
    .clk(clk), .rst(rst), .rise(rise), .lr(sync_lines[LANES]),
    .dual_en(dual_en), .fmt_code(fmt_code), .lr_swap(lr_swap),
    .dual_lj(dual_lj), .dual_w24(dual_w24),
    .cap_l(cap_l), .cap_r(cap_r), .cap_skip(cap_skip),
    .cap_len(cap_len), .cap_dual(cap_dual)
  );

  audrx_pair #(.OUT_W(OUT_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_pair (
    .clk(clk), .rst(rst), .cap_l(cap_l), .cap_r(cap_r), .cap_skip(cap_skip),
    .cap_len(cap_len), .cap_dual(cap_dual), .lane0(lane_sh[0]),
    .lane1(lane_sh[1]), .left_out(left_out), .right_out(right_out),
    .pair_valid(pair_valid)
  );

endmodule

// File: tb/audrx_top_tb.sv
module audrx_top_tb;
  logic        clk = 0, rst = 1, bclk = 0, lrclk = 0, sd = 0, sd2 = 0;
  logic        dual_en = 0, lr_swap = 0, dual_lj = 0, dual_w24 = 0;
  logic [2:0]  fmt = 0;
  logic [23:0] left_out, right_out;
  logic        pair_valid;

  int n_chk = 0, n_err = 0, n_got = 0, dbl = 0;
  bit prev_v = 0;
  logic [23:0] got_l [0:15];
  logic [23:0] got_r [0:15];

  always #10 clk = ~clk;

  audrx_top u_dut (
    .clk(clk), .rst(rst), .bclk_in(bclk), .lrclk_in(lrclk), .sdata_in(sd),
    .sdata2_in(sd2), .dual_en(dual_en), .fmt_code(fmt), .lr_swap(lr_swap),
    .dual_lj(dual_lj), .dual_w24(dual_w24), .left_out(left_out),
    .right_out(right_out), .pair_valid(pair_valid)
  );

  always @(negedge clk) begin
    if (pair_valid) begin
      if (n_got < 16) begin
        got_l[n_got] = left_out;
        got_r[n_got] = right_out;
      end
      n_got++;
      if (prev_v) dbl++;
    end
    prev_v = pair_valid;
  end

  task automatic chk(input bit ok, input string tag, input logic [23:0] act,
                     input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic l, input logic d, input logic d2);
    @(negedge clk);
    lrclk = l; sd = d; sd2 = d2;
    repeat (3) @(negedge clk);
    bclk = 1;
    repeat (4) @(negedge clk);
    bclk = 0;
  endtask

  function automatic logic [23:0] pat(input int f, input int ch, input int n,
                                      input int salt);
    int m, v;
    m = (1 << n) - 1;
    case (f)
      0:       v = ch ? (1 << (n - 1)) : ((1 << (n - 1)) - 1);
      1:       v = ch ? m : ((32'h5A3C96 + salt * 32'h01F3) & m);
      default: v = ch ? ((32'hC3A5F1 ^ (salt * 32'h0777)) & m) : 1;
    endcase
    return 24'(v);
  endfunction

  function automatic logic [23:0] sx(input logic [23:0] v, input int n);
    int m;
    m = (1 << n) - 1;
    return v[n-1] ? 24'((int'(v) | ~m) & 32'hFFFFFF) : v;
  endfunction

  task automatic do_reset(input string tag);
    for (int i = 0; i < 10; i++) send_bit(1'b1, i[0], 1'b1);
    for (int i = 0; i < 7; i++)  send_bit(1'b0, 1'b1, i[1]);
    @(negedge clk) rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(left_out == 0 && right_out == 0 && pair_valid == 0,
        {"R12 reset clears outputs ", tag}, left_out | right_out, 24'h0);
    n_got = 0;
  endtask

  task automatic compare(input string tag, input int n, input int salt);
    chk(n_got == 3, {"R7 pair count ", tag}, 24'(n_got), 24'd3);
    for (int f = 0; f < 3; f++) begin
      logic [23:0] el, er;
      el = sx(pat(f, 0, n, salt), n);
      er = sx(pat(f, 1, n, salt), n);
      chk(got_l[f] === el, $sformatf("R1 R8 %s frame %0d left", tag, f), got_l[f], el);
      chk(got_r[f] === er, $sformatf("R1 R8 %s frame %0d right", tag, f), got_r[f], er);
    end
  endtask

  task automatic run_normal(input int code, input logic pol);
    int n, kind;
    string tag;
    case (code)
      0: begin n = 16; kind = 0; end
      1: begin n = 20; kind = 0; end
      2: begin n = 24; kind = 0; end
      3: begin n = 24; kind = 1; end
      4: begin n = 16; kind = 2; end
      5: begin n = 24; kind = 2; end
      6: begin n = 20; kind = 2; end
      default: begin n = 20; kind = 1; end
    endcase
    tag = $sformatf("R2 %s %s code=%0d swap=%0d", (kind == 0) ? "R3" :
                    (kind == 1) ? "R4" : "R5", pol ? "R6" : "r6", code, pol);
    dual_en = 0; fmt = 3'(code); lr_swap = pol;
    do_reset(tag);
    send_bit(pol, 1'b0, 1'b1);
    send_bit(pol, 1'b0, 1'b0);
    for (int f = 0; f < 3; f++) begin
      for (int ch = 0; ch < 2; ch++) begin
        logic [23:0] w;
        logic lvl;
        w = pat(f, ch, n, code);
        lvl = ch ? pol : ~pol;
        for (int j = 0; j < 32; j++) begin
          logic b;
          b = 1'b1;
          if (kind == 0 && j >= 32 - n) b = w[31 - j];
          if (kind == 1 && j < n) b = w[n - 1 - j];
          if (kind == 2 && j >= 1 && j <= n) b = w[n - j];
          send_bit(lvl, b, j[0]);
        end
      end
    end
    for (int j = 0; j < 4; j++) send_bit(~pol, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    compare(tag, n, code);
  endtask

  task automatic run_dual(input logic lj, input logic w24, input logic pol);
    int n, salt;
    logic h1;
    string tag;
    n = w24 ? 24 : 20;
    salt = 9 + int'(lj) * 2 + int'(w24);
    h1 = lj ? pol : ~pol;
    tag = $sformatf("%s R11 dual w=%0d swap=%0d", lj ? "R9" : "R10", n, pol);
    dual_en = 1; dual_lj = lj; dual_w24 = w24; lr_swap = pol; fmt = 3'd0;
    do_reset(tag);
    send_bit(~h1, 1'b0, 1'b0);
    send_bit(~h1, 1'b0, 1'b0);
    for (int f = 0; f < 3; f++) begin
      logic [23:0] wl, wr;
      wl = pat(f, 0, n, salt);
      wr = pat(f, 1, n, salt);
      for (int j = 0; j < 32; j++) begin
        logic bl, br;
        bl = 1'b1; br = 1'b1;
        if (lj && j < n) begin bl = wl[n - 1 - j]; br = wr[n - 1 - j]; end
        if (!lj && j >= 32 - n) begin bl = wl[31 - j]; br = wr[31 - j]; end
        send_bit((j < 16) ? h1 : ~h1, bl, br);
      end
    end
    for (int j = 0; j < 4; j++) send_bit(h1, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    compare(tag, n, salt);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R7 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 8; c++) run_normal(c, p[0]);
    for (int p = 0; p < 2; p++)
      for (int m = 0; m < 4; m++) run_dual(m[1], m[0], p[0]);
    chk(dbl == 0, "R7 valid lasts one cycle", 24'(dbl), 24'd0);
    finish_run();
  end

endmodule